// File: doc/BRIEF.md
# SPI Command Sequencer and Shifter

This block is an SPI master that receives no fixed control registers. A 16-bit instruction stream tells it what to do: shift words, drive the eight chip-select lines, update its clock divider, mode and word length, pause, invert chip-select polarity, or raise a marker that software can wait on. Words to send arrive on a 32-bit transmit stream and received words leave on a 32-bit receive stream. All three streams use a valid/ready handshake.

Instructions run one at a time. Setup instructions take a single cycle. Transfers, chip-select delays and sleeps hold off the next instruction until they finish. When a transfer needs a transmit word that has not arrived, or a receive slot that the consumer has not freed, SCLK stays at its idle level until the stream catches up. Markers appear as a one-cycle strobe with an 8-bit tag.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset, `cs_n` is 8'hFF, `sclk` and `sdo` are 0, `sdo_oe` is 1, `sync_valid` is 0 and `cmd_ready` is 1. The divider is 0, the config is 0 and the word length is 8.
- R2: An instruction carries the opcode in bits [15:12], argument A in bits [11:8] and argument B in bits [7:0]. It is accepted when `cmd_valid` and `cmd_ready` are both high. A register write, an inversion load, a marker, or a chip-select update with A=0 leaves `cmd_ready` high on the next cycle.
- R3: Opcode 0 is a transfer of B+1 words. A bit 0 enables sending and A bit 1 enables receiving. Each word produces exactly one SCLK pulse per bit, and the word is sent most significant bit first, starting at bit (length-1) of `tx_data`.
- R4: A received word is right-justified in `rx_data` with the upper bits zero. With `sdi` tied to `sdo`, it equals the low bits of the transmitted word.
- R5: Opcode 2 with A=1 loads the config from B[3:0]. Bit 0 selects the late-capture phase and bit 1 sets the SCLK idle level. With bit 0 clear, `sdi` is captured on the first edge of each pulse and `sdo` changes on the second edge. With bit 0 set, `sdo` changes on the first edge and `sdi` is captured on the second.
- R6: Opcode 2 with A=0 loads the divider d = B. Each SCLK high or low phase inside a pulse lasts d+1 clock cycles.
- R7: Opcode 2 with A=2 loads the word length from B, with a valid range of 1 to 32.
- R8: When the send flag is clear, no transmit word is taken and `sdo` holds the idle level given by config bit 3. With config bit 2 (three-wire) set, `sdo_oe` is low during such a transfer. Otherwise `sdo_oe` stays high.
- R9: When the receive flag is clear, `rx_valid` never rises.
- R10: While the transmit stream is empty or the receive stream is full, SCLK holds still. `rx_valid` and `rx_data` stay stable until `rx_ready`.
- R11: Opcode 1 sets `cs_n` to B XOR the inversion mask. It then waits 2*A*(d+1) cycles before the next instruction is accepted.
- R12: Opcode 4 loads the inversion mask from B. `cs_n` does not change until the next opcode 1.
- R13: Opcode 3 with A=0 drives `sync_valid` high for exactly the cycle after acceptance, with `sync_id` = B.
- R14: Opcode 3 with A=1 keeps `cmd_ready` low for 2*(B+1)*(d+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Instruction present |
| cmd_ready | output | 1 | Instruction accepted this cycle |
| cmd_data | input | 16 | Instruction word |
| tx_valid | input | 1 | Transmit word present |
| tx_ready | output | 1 | Transmit word taken |
| tx_data | input | 32 | Transmit word, right-justified |
| rx_valid | output | 1 | Received word present |
| rx_ready | input | 1 | Consumer takes received word |
| rx_data | output | 32 | Received word, right-justified |
| sync_valid | output | 1 | Marker strobe |
| sync_id | output | 8 | Marker tag |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo (low during three-wire receive) |
| sdi | input | 1 | Serial data in |
| cs_n | output | 8 | Chip selects, active low before inversion |

## Verification
The bench ties `sdi` to `sdo` and sweeps all four clock modes against word lengths 1, 7, 8, 13 and 32 at two divider settings. An echoed word that comes back intact shows that capture and launch sit on opposite edges and that the word is right-justified. A separate edge-by-edge record of `sdo` shows MSB-first ordering. Pulse counts and measured phase widths separate word-length faults from divider faults. Receive-only and send-only transfers with idle-high and three-wire settings expose idle-level and output-enable handling. Throttled transmit and receive streams show stall behaviour. Sleep and chip-select delays are timed across several divider and count values against the arithmetic formula.

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [15:0]       cmd_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              sync_valid,
  output logic [7:0]        sync_id,
  output logic              sclk,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sdi,
  output logic [7:0]        cs_n
);
  localparam int BW = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_BIT, S_PUSH, S_WAIT} st_t;

  st_t              st;
  logic [7:0]       div_q, cnt, words, inv_q, cs_q;
  logic [3:0]       cfg;
  logic [BW-1:0]    bits_q, bitc;
  logic             wr_q, rd_q, phase;
  logic [DATA_W:0]  sh;
  logic [DATA_W-1:0] rsh;
  logic [9:0]       wl;

  wire [3:0] op = cmd_data[15:12];
  wire [3:0] a1 = cmd_data[11:8];
  wire [7:0] a2 = cmd_data[7:0];

  wire timed    = (st == S_BIT) || (st == S_WAIT);
  wire tick     = timed && (cnt == div_q);
  wire lead     = tick && !phase;
  wire trail    = tick && phase;
  wire shift_ev = cfg[0] ? lead : trail;
  wire samp_ev  = cfg[0] ? trail : lead;
  wire active   = (st == S_LOAD) || (st == S_BIT) || (st == S_PUSH);
  wire last_bit = (bitc == bits_q - BW'(1));

  wire [DATA_W-1:0] aligned = tx_data << (BW'(DATA_W) - bits_q);
  wire [BW-1:0]     bits_in = (a2 == 8'd0 || a2 > 8'(DATA_W)) ? BW'(DATA_W) : a2[BW-1:0];

  assign cmd_ready = (st == S_IDLE);
  assign tx_ready  = (st == S_LOAD) && wr_q;
  assign rx_valid  = (st == S_PUSH);
  assign rx_data   = rsh;
  assign sclk      = cfg[1] ^ ((st == S_BIT) && phase);
  assign sdo       = (active && wr_q) ? sh[DATA_W] : cfg[3];
  assign sdo_oe    = !(cfg[2] && active && !wr_q);
  assign cs_n      = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      div_q      <= '0;
      cnt        <= '0;
      words      <= '0;
      inv_q      <= '0;
      cs_q       <= '1;
      cfg        <= '0;
      bits_q     <= BW'(8);
      bitc       <= '0;
      wr_q       <= 1'b0;
      rd_q       <= 1'b0;
      phase      <= 1'b0;
      sh         <= '0;
      rsh        <= '0;
      wl         <= '0;
      sync_valid <= 1'b0;
      sync_id    <= '0;
    end else begin
      sync_valid <= 1'b0;
      cnt <= (tick || !timed) ? 8'd0 : cnt + 8'd1;
      case (st)
        S_IDLE: if (cmd_valid) begin
          case (op)
            4'd0: begin
              wr_q  <= a1[0];
              rd_q  <= a1[1];
              words <= a2;
              st    <= S_LOAD;
            end
            4'd1: begin
              cs_q <= a2 ^ inv_q;
              if (a1 != 4'd0) begin
                wl <= {5'd0, a1, 1'b0} - 10'd1;
                st <= S_WAIT;
              end
            end
            4'd2: begin
              case (a1)
                4'd0: div_q  <= a2;
                4'd1: cfg    <= a2[3:0];
                4'd2: bits_q <= bits_in;
                default: ;
              endcase
            end
            4'd3: begin
              if (a1 == 4'd0) begin
                sync_valid <= 1'b1;
                sync_id    <= a2;
              end else if (a1 == 4'd1) begin
                wl <= {1'b0, a2, 1'b1};
                st <= S_WAIT;
              end
            end
            4'd4: inv_q <= a2;
            default: ;
          endcase
        end
        S_LOAD: if (!wr_q || tx_valid) begin
          sh    <= cfg[0] ? {cfg[3], aligned} : {aligned, cfg[3]};
          rsh   <= '0;
          bitc  <= '0;
          phase <= 1'b0;
          st    <= S_BIT;
        end
        S_BIT: if (tick) begin
          phase <= !phase;
          if (shift_ev) sh  <= {sh[DATA_W-1:0], cfg[3]};
          if (samp_ev)  rsh <= {rsh[DATA_W-2:0], sdi};
          if (phase) begin
            if (last_bit) begin
              if (rd_q) st <= S_PUSH;
              else if (words == 8'd0) st <= S_IDLE;
              else begin
                words <= words - 8'd1;
                st    <= S_LOAD;
              end
            end else begin
              bitc <= bitc + BW'(1);
            end
          end
        end
        S_PUSH: if (rx_ready) begin
          if (words == 8'd0) st <= S_IDLE;
          else begin
            words <= words - 8'd1;
            st    <= S_LOAD;
          end
        end
        S_WAIT: if (tick) begin
          if (wl == 10'd0) st <= S_IDLE;
          else wl <= wl - 10'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [15:0] cmd_data,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [31:0] rx_data,
  input logic        sclk,
  input logic [7:0]  cs_n,
  input logic        sync_valid
);
  assert_stall_sclk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> $stable(sclk));

  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_one_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ready, tx_ready, rx_valid}));

  assert_sync_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |-> $past(cmd_valid && cmd_ready && cmd_data[15:8] == 8'h30));

  assert_cs_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> $past(cmd_valid && cmd_ready && cmd_data[15:12] == 4'h1));
endmodule

bind spi_cmd_seq spi_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .sclk(sclk), .cs_n(cs_n), .sync_valid(sync_valid)
);

// File: tb/sim_spi_cmd_seq.sv
module sim_spi_cmd_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready;
  logic [15:0] cmd_data = '0;
  logic        tx_valid = 1'b0, tx_ready;
  logic [31:0] tx_data = '0;
  logic        rx_valid, rx_ready = 1'b0;
  logic [31:0] rx_data;
  logic        sync_valid;
  logic [7:0]  sync_id;
  logic        sclk, sdo, sdo_oe, sdi;
  logic [7:0]  cs_n;

  assign sdi = sdo;

  spi_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sync_valid(sync_valid), .sync_id(sync_id), .sclk(sclk), .sdo(sdo),
    .sdo_oe(sdo_oe), .sdi(sdi), .cs_n(cs_n)
  );

  int total = 0, bad = 0;
  int cur_div = 0, cur_b = 8;
  logic cur_cpol = 1'b0, cur_idle = 1'b0, cur_tw = 1'b0;

  int edges = 0, hp = 0, hp_bad = 0, rxv_seen = 0, txr_seen = 0, oe_low = 0;
  logic [31:0] mon = '0;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    hp++;
    if (sclk !== prev_sclk) begin
      if (sclk == cur_cpol) begin
        if (hp != cur_div + 1) hp_bad++;
      end else begin
        edges++;
        mon = {mon[30:0], sdo};
        hp = 0;
      end
    end
    prev_sclk = sclk;
    if (rx_valid) rxv_seen++;
    if (tx_ready) txr_seen++;
    if (!sdo_oe) oe_low++;
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [15:0] c, output int busy);
    cmd_valid = 1'b1;
    cmd_data  = c;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    busy = 0;
    while (!cmd_ready) begin
      busy++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] wd(logic [31:0] base, int i);
    return base ^ (32'(i) * 32'h9E3779B1) ^ (32'(i) << 7);
  endfunction

  task automatic setup(int dv, logic [3:0] cf, int b);
    int bz;
    cur_div = dv; cur_cpol = cf[1]; cur_idle = cf[3]; cur_tw = cf[2]; cur_b = b;
    send_cmd({8'h20, 8'(dv)}, bz);
    send_cmd({8'h21, 4'h0, cf}, bz);
    send_cmd({8'h22, 8'(b)}, bz);
  endtask

  task automatic xfer(int nw, bit wr, bit rd, logic [31:0] base, int tgap, int rgap);
    logic [31:0] got [8];
    logic [31:0] mask;
    int busy;
    mask = (cur_b >= 32) ? 32'hFFFF_FFFF : ((32'd1 << cur_b) - 32'd1);
    @(negedge clk);
    edges = 0; hp_bad = 0; rxv_seen = 0; txr_seen = 0; oe_low = 0; mon = '0;
    fork
      send_cmd({4'h0, 2'b00, rd, wr, 8'(nw - 1)}, busy);
      begin
        if (wr) for (int i = 0; i < nw; i++) begin
          repeat (tgap) @(negedge clk);
          tx_valid = 1'b1;
          tx_data  = wd(base, i);
          while (!tx_ready) @(negedge clk);
          @(negedge clk);
          tx_valid = 1'b0;
        end
      end
      begin
        if (rd) for (int i = 0; i < nw; i++) begin
          repeat (rgap) @(negedge clk);
          rx_ready = 1'b1;
          while (!rx_valid) @(negedge clk);
          got[i] = rx_data;
          @(negedge clk);
          rx_ready = 1'b0;
        end
      end
    join
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    check("R3 pulse count", 64'(edges), 64'(nw * cur_b));
    check("R6 phase width", 64'(hp_bad), 64'd0);
    check("R5 idle level", 64'(sclk), 64'(cur_cpol));
    check("R8 output enable", 64'(oe_low != 0), 64'(cur_tw && !wr));
    if (wr) check("R3 msb first", 64'(mon & mask), 64'(wd(base, nw - 1) & mask));
    else    check("R8 no tx taken", 64'(txr_seen), 64'd0);
    if (!rd) check("R9 no rx", 64'(rxv_seen), 64'd0);
    if (rd) for (int i = 0; i < nw; i++) begin
      if (wr) check("R4 echo", 64'(got[i]), 64'(wd(base, i) & mask));
      else    check("R8 idle sdo", 64'(got[i]), 64'(cur_idle ? mask : 32'd0));
    end
  endtask

  bit finished = 1'b0;
  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    wrap_up();
  end

  initial begin
    int bz;
    int blist [5] = '{1, 7, 8, 13, 32};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cs_n", 64'(cs_n), 64'hFF);
    check("R1 sclk", 64'(sclk), 64'd0);
    check("R1 sdo", 64'(sdo), 64'd0);
    check("R1 sdo_oe", 64'(sdo_oe), 64'd1);
    check("R1 sync", 64'(sync_valid), 64'd0);
    check("R1 ready", 64'(cmd_ready), 64'd1);

    // R7: default word length of 8 with reset divider and config
    xfer(1, 1'b1, 1'b1, 32'hA5C3_0F96, 0, 0);

    // R13 marker
    send_cmd(16'h305A, bz);
    check("R13 strobe", 64'(sync_valid), 64'd1);
    check("R13 tag", 64'(sync_id), 64'h5A);
    check("R2 single cycle", 64'(bz), 64'd0);
    @(negedge clk);
    check("R13 one cycle", 64'(sync_valid), 64'd0);

    // R12 / R11 chip selects
    send_cmd(16'h4A0F, bz);
    check("R12 deferred", 64'(cs_n), 64'hFF);
    send_cmd(16'h2001, bz);
    cur_div = 1;
    send_cmd(16'h13FE, bz);
    check("R11 inverted mask", 64'(cs_n), 64'hF1);
    check("R11 delay", 64'(bz), 64'(2 * 3 * 2));
    send_cmd(16'h4000, bz);
    check("R12 unchanged", 64'(cs_n), 64'hF1);
    send_cmd(16'h10FF, bz);
    check("R11 release", 64'(cs_n), 64'hFF);
    check("R11 no delay", 64'(bz), 64'd0);

    // R14 sleep sweep
    foreach (blist[k]) if (k < 3) begin
      for (int n = 0; n < 6; n += 2) begin
        int dv;
        dv = (k == 0) ? 0 : (k == 1) ? 1 : 3;
        send_cmd({8'h20, 8'(dv)}, bz);
        send_cmd({8'h31, 8'(n)}, bz);
        check("R14 sleep", 64'(bz), 64'(2 * (n + 1) * (dv + 1)));
      end
    end

    // R3 R4 R5 R6 R7 mode/length/divider sweep with loopback
    for (int dv = 0; dv < 3; dv += 2)
      for (int md = 0; md < 4; md++)
        foreach (blist[j]) begin
          setup(dv, 4'(md), blist[j]);
          xfer(2, 1'b1, 1'b1, 32'h1357_9BDF + 32'(md * 77 + j), 0, 0);
        end

    // R8 receive only, idle high, three-wire
    setup(1, 4'b1100, 5);
    xfer(2, 1'b0, 1'b1, 32'h0, 0, 0);
    setup(0, 4'b0001, 9);
    xfer(1, 1'b0, 1'b1, 32'h0, 0, 0);
    // R9 send only, three-wire does not release while sending
    setup(0, 4'b0110, 12);
    xfer(2, 1'b1, 1'b0, 32'hCAFE_F00D, 0, 0);
    // R10 throttled streams
    setup(1, 4'b0011, 16);
    xfer(3, 1'b1, 1'b1, 32'h8421_7E3C, 5, 7);
    setup(0, 4'b0000, 32);
    xfer(3, 1'b1, 1'b1, 32'hF0F0_1234, 9, 3);

    wrap_up();
  end
endmodule